// File: doc/BRIEF.md
# Masked-Trigger Sample Address Sequencer

This block drives the write side of a capture buffer. A host loads a five-byte setup word one bit at a time. The word holds the address counter start value, an 8-bit trigger pattern, a don't-care mask and an option byte. When the block is armed, it writes one sample per clock and steps a 15-bit address around a 32K-location circular buffer. It compares the eight probe inputs against the masked pattern on each sample. Once the trigger has fired, it keeps writing for a programmable number of further samples and then stops.

The halt address is the last location written, so the buffer holds history from before the event and from after it. The host reads the 16-bit counter back one bit at a time to find where the event sits in the buffer. An abort strobe stops writing in the same cycle it is raised. A done flag tells the host that the capture has ended on its own.

Top module: `sas_seq`

## Requirements
- R1: The setup word is shifted in least significant bit first while `cfg_en_i` is high, one bit per clock. The 40 bits form five bytes: preload low (bits 7:0), preload high (15:8), trigger level (23:16), trigger mask (31:24) and option (39:32). A `cfg_commit_i` pulse makes the word active, overwrites the counter with the preload value, returns the block to idle and clears done.
- R2: With option bit 0 set, the trigger fires on a sample where `probe_i` equals the level byte on every bit whose mask bit is 0. A mask bit of 1 means that bit is don't care, so a mask of 0xFF fires on the first sample after arming.
- R3: Option bit 1 inverts the trigger, so it fires on the first sample that does not match. With option bit 0 clear, the trigger fires on the first sample after arming.
- R4: While capturing, `wr_en_o` is high on every clock and `addr_o` steps by one per clock. The first sample after `arm_i` is written at the preload address. The address wraps from 0x7FFF to 0x0000.
- R5: The post-trigger count D is sampled from `post_cnt_i` at arm. Exactly D samples are written after the trigger sample, so D = 0 halts on the clock right after the trigger.
- R6: After halt, `done_o` is high and `wr_en_o` is low. Done stays high until the next `arm_i` or `cfg_commit_i`.
- R7: `rd_bit_o` shows one counter bit. The index starts at bit 0 and advances on each `rd_step_i` pulse, so the value comes out low byte then high byte, least significant bit first. After halt the counter holds the last address written. The index returns to 0 on halt, arm, commit and abort.
- R8: `abort_i` drops `wr_en_o` in the same cycle and returns the block to idle. The counter keeps the address of the aborted cycle and done is not set.
- R9: After reset, done and write enable are low and the counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| probe_i | input | 8 | Digital probe inputs |
| post_cnt_i | input | 16 | Post-trigger sample count, taken at arm |
| arm_i | input | 1 | Start a capture |
| abort_i | input | 1 | Stop the capture at once |
| cfg_en_i | input | 1 | Shift one setup bit |
| cfg_bit_i | input | 1 | Setup data bit |
| cfg_commit_i | input | 1 | Make the shifted setup word active |
| rd_step_i | input | 1 | Advance the readout bit index |
| rd_bit_o | output | 1 | Selected counter bit |
| addr_o | output | 15 | Sample RAM address |
| wr_en_o | output | 1 | Sample RAM write strobe |
| done_o | output | 1 | Capture halted after the trigger delay |

## Verification
A corrupted counter shows up in two places. `addr_o` is wrong on the very next write, and the serial readout gives the wrong halt address, usually off by the trigger position plus the delay. A wrong comparator or delay count changes how many write strobes appear before done rises. The bench counts those strobes for every vector, so such an error is caught by the end of that capture. A state machine that stays active after abort or halt shows up within one clock as a write strobe while done is high or after the abort.

// File: rtl/sas_pkg.sv
package sas_pkg;
    localparam int BYTE_W   = 8;
    localparam int CFG_NB   = 5;
    localparam int CFG_W    = BYTE_W * CFG_NB;
    localparam int CNT_W    = 16;
    localparam int ADDR_W   = 15;
    localparam int PROBE_W  = 8;
    localparam int DLY_W    = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_POST = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic                  invert;
        logic                  pat_en;
        logic [PROBE_W-1:0]    mask;
        logic [PROBE_W-1:0]    level;
        logic [CNT_W-1:0]      preload;
    } setup_t;
endpackage

// File: rtl/sas_cfg_shift.sv
module sas_cfg_shift
    import sas_pkg::*;
#(
    parameter int SR_W = CFG_W
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   shift_en,
    input  logic   shift_bit,
    input  logic   commit,
    output setup_t active_o,
    output logic [CNT_W-1:0] staged_pre_o
);
    localparam int LVL_LO = CNT_W;
    localparam int MSK_LO = CNT_W + PROBE_W;
    localparam int OPT_LO = CNT_W + 2 * PROBE_W;

    typedef struct packed {
        logic [SR_W-1:0] sr;
        setup_t          act;
    } cfg_st_t;

    cfg_st_t s_d, s_q;
    setup_t  staged;

    always_comb begin
        staged.preload = s_q.sr[CNT_W-1:0];
        staged.level   = s_q.sr[LVL_LO +: PROBE_W];
        staged.mask    = s_q.sr[MSK_LO +: PROBE_W];
        staged.pat_en  = s_q.sr[OPT_LO];
        staged.invert  = s_q.sr[OPT_LO + 1];
    end

    always_comb begin
        s_d = s_q;
        if (shift_en) s_d.sr = {shift_bit, s_q.sr[SR_W-1:1]};
        if (commit)   s_d.act = staged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o     = s_q.act;
    assign staged_pre_o = staged.preload;

    // R1
    commit_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> active_o == $past(staged));
endmodule

// File: rtl/sas_trig_match.sv
module sas_trig_match
    import sas_pkg::*;
#(
    parameter int W = PROBE_W
) (
    input  logic [W-1:0] probe,
    input  logic [W-1:0] level,
    input  logic [W-1:0] mask,
    input  logic         pat_en,
    input  logic         invert,
    output logic         hit
);
    logic [W-1:0] diff_care;
    logic         eq;

    always_comb begin
        diff_care = (probe ^ level) & ~mask;
        eq        = (diff_care == '0);
        hit       = pat_en ? (eq ^ invert) : 1'b1;
    end

    // R2
    always_comb begin
        if (pat_en && !invert && (&mask))
            full_mask_chk: assert (hit);
    end
endmodule

// File: rtl/sas_addr_ctr.sv
module sas_addr_ctr
    import sas_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          step,
    input  logic          rd_clr,
    input  logic          rd_step,
    output logic [AW-1:0] addr_o,
    output logic          rd_bit_o
);
    localparam int IW = $clog2(CW);
    localparam logic [AW-1:0] ONE = AW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
    } ctr_st_t;

    ctr_st_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (load)
            c_d.cnt = load_val;
        else if (step)
            c_d.cnt = {{(CW-AW){1'b0}}, c_q.cnt[AW-1:0] + ONE};
        if (rd_clr)       c_d.idx = '0;
        else if (rd_step) c_d.idx = c_q.idx + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign addr_o   = c_q.cnt[AW-1:0];
    assign rd_bit_o = c_q.cnt[c_q.idx];

    // R4
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && (&addr_o)) |=> addr_o == '0);
    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> addr_o == AW'($past(addr_o) + ONE));
    // R1
    preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> c_q.cnt == $past(load_val));
endmodule

// File: rtl/sas_seq.sv
module sas_seq
    import sas_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PROBE_W-1:0]  probe_i,
    input  logic [DLY_W-1:0]    post_cnt_i,
    input  logic                arm_i,
    input  logic                abort_i,
    input  logic                cfg_en_i,
    input  logic                cfg_bit_i,
    input  logic                cfg_commit_i,
    input  logic                rd_step_i,
    output logic                rd_bit_o,
    output logic [ADDR_W-1:0]   addr_o,
    output logic                wr_en_o,
    output logic                done_o
);
    typedef struct packed {
        seq_state_e       st;
        logic [DLY_W-1:0] dly;
    } seq_st_t;

    seq_st_t q, d;
    setup_t  setup;
    logic [CNT_W-1:0] staged_pre;
    logic    hit, step, rd_clr, active;

    sas_cfg_shift #(.SR_W(CFG_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .shift_en     (cfg_en_i),
        .shift_bit    (cfg_bit_i),
        .commit       (cfg_commit_i),
        .active_o     (setup),
        .staged_pre_o (staged_pre)
    );

    sas_trig_match #(.W(PROBE_W)) u_trig (
        .probe  (probe_i),
        .level  (setup.level),
        .mask   (setup.mask),
        .pat_en (setup.pat_en),
        .invert (setup.invert),
        .hit    (hit)
    );

    sas_addr_ctr #(.CW(CNT_W), .AW(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_commit_i),
        .load_val (staged_pre),
        .step     (step),
        .rd_clr   (rd_clr),
        .rd_step  (rd_step_i),
        .addr_o   (addr_o),
        .rd_bit_o (rd_bit_o)
    );

    assign active = (q.st == ST_WAIT) || (q.st == ST_POST);

    always_comb begin
        d      = q;
        step   = 1'b0;
        rd_clr = 1'b0;
        if (cfg_commit_i) begin
            d.st   = ST_IDLE;
            rd_clr = 1'b1;
        end else if (abort_i) begin
            if (active) begin
                d.st   = ST_IDLE;
                rd_clr = 1'b1;
            end
        end else if (arm_i) begin
            d.st   = ST_WAIT;
            d.dly  = post_cnt_i;
            rd_clr = 1'b1;
        end else begin
            unique case (q.st)
                ST_WAIT: begin
                    if (hit && (q.dly == '0)) begin
                        d.st   = ST_DONE;
                        rd_clr = 1'b1;
                    end else begin
                        if (hit) d.st = ST_POST;
                        step = 1'b1;
                    end
                end
                ST_POST: begin
                    if (q.dly == DLY_W'(1)) begin
                        d.st   = ST_DONE;
                        rd_clr = 1'b1;
                    end else begin
                        d.dly = q.dly - 1'b1;
                        step  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, dly: '0};
        else        q <= d;
    end

    assign wr_en_o = active && !abort_i && !cfg_commit_i && !arm_i;
    assign done_o  = (q.st == ST_DONE);

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !arm_i && !cfg_commit_i) |=> done_o);
    // R6
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wr_en_o);
    // R5
    zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && hit && q.dly == '0 && !abort_i && !arm_i && !cfg_commit_i)
        |=> done_o);
    // R8
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && active && !cfg_commit_i) |=> (!done_o && !wr_en_o && !$past(wr_en_o)));
endmodule

// File: tb/sas_seq_tb.sv
module sas_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  probe_i = '0;
    logic [15:0] post_cnt_i = '0;
    logic        arm_i = 1'b0, abort_i = 1'b0;
    logic        cfg_en_i = 1'b0, cfg_bit_i = 1'b0, cfg_commit_i = 1'b0;
    logic        rd_step_i = 1'b0;
    logic        rd_bit_o, wr_en_o, done_o;
    logic [14:0] addr_o;

    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    sas_seq u_dut (
        .clk(clk), .rst_n(rst_n), .probe_i(probe_i), .post_cnt_i(post_cnt_i),
        .arm_i(arm_i), .abort_i(abort_i), .cfg_en_i(cfg_en_i), .cfg_bit_i(cfg_bit_i),
        .cfg_commit_i(cfg_commit_i), .rd_step_i(rd_step_i), .rd_bit_o(rd_bit_o),
        .addr_o(addr_o), .wr_en_o(wr_en_o), .done_o(done_o)
    );

    typedef struct packed {
        logic [15:0] pre;
        logic [7:0]  lvl;
        logic [7:0]  msk;
        logic [7:0]  opt;
        logic [15:0] dly;
        logic [7:0]  idle;
        logic [7:0]  hit;
        logic [7:0]  t;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{16'h0100, 8'h5A, 8'h00, 8'h01, 16'd3,  8'h00, 8'h5A, 8'd4},
        '{16'h0000, 8'hF0, 8'h0F, 8'h01, 16'd0,  8'h00, 8'hF3, 8'd2},
        '{16'h1234, 8'h77, 8'hFF, 8'h01, 16'd5,  8'h00, 8'h00, 8'd0},
        '{16'h7FFE, 8'h81, 8'h00, 8'h01, 16'd2,  8'h80, 8'h81, 8'd3},
        '{16'h0040, 8'h3C, 8'h00, 8'h03, 16'd1,  8'h3C, 8'h00, 8'd2},
        '{16'h2000, 8'hAA, 8'h00, 8'h00, 16'd4,  8'h00, 8'h00, 8'd0},
        '{16'h7FFF, 8'h00, 8'hFF, 8'h01, 16'd0,  8'h00, 8'h00, 8'd0},
        '{16'h0500, 8'h11, 8'h00, 8'h01, 16'd10, 8'h10, 8'h11, 8'd6}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic send_cfg(input logic [15:0] pre, input logic [7:0] lvl,
                            input logic [7:0] msk, input logic [7:0] opt);
        logic [39:0] w;
        w = {opt, msk, lvl, pre};
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            cfg_en_i  = 1'b1;
            cfg_bit_i = w[i];
        end
        @(negedge clk);
        cfg_en_i     = 1'b0;
        cfg_commit_i = 1'b1;
        @(negedge clk);
        cfg_commit_i = 1'b0;
    endtask

    task automatic read_cnt(output logic [15:0] v);
        for (int i = 0; i < 16; i++) begin
            #1 v[i] = rd_bit_o;
            rd_step_i = 1'b1;
            @(negedge clk);
        end
        rd_step_i = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        int writes, expw;
        bit seen;
        logic [15:0] expc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R9 reset state
        chk(!done_o, "R9", "done after reset", done_o, 0);
        chk(!wr_en_o, "R9", "wr_en after reset", wr_en_o, 0);
        read_cnt(rv);
        chk(rv == 16'h0, "R9", "counter after reset", rv, 0);

        // Vector table: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            send_cfg(VEC[v].pre, VEC[v].lvl, VEC[v].msk, VEC[v].opt);
            #1;
            chk(!done_o, "R1", "done after commit", done_o, 0);
            post_cnt_i = VEC[v].dly;
            arm_i      = 1'b1;
            probe_i    = (VEC[v].t == 0) ? VEC[v].hit : VEC[v].idle;
            @(negedge clk);
            arm_i  = 1'b0;
            writes = 0;
            seen   = 1'b0;
            for (int k = 0; k < 200; k++) begin
                probe_i = (k >= int'(VEC[v].t)) ? VEC[v].hit : VEC[v].idle;
                #1;
                if (done_o) begin
                    seen = 1'b1;
                    break;
                end
                if (wr_en_o) begin
                    writes++;
                    if (writes == 1)
                        chk(addr_o == VEC[v].pre[14:0], "R4", "first write address",
                            addr_o, VEC[v].pre[14:0]);
                end
                @(negedge clk);
            end
            expw = int'(VEC[v].t) + int'(VEC[v].dly) + 1;
            expc = (VEC[v].pre + 16'(VEC[v].t) + VEC[v].dly) & 16'h7FFF;
            chk(seen, "R6", "done reached", seen, 1);
            chk(writes == expw, "R5", "write strobes to halt", writes, expw);
            repeat (3) @(negedge clk);
            #1;
            chk(done_o && !wr_en_o, "R6", "done held, writes idle", {done_o, wr_en_o}, 2'b10);
            @(negedge clk);
            read_cnt(rv);
            chk(rv == expc, "R7", "halt address readback", rv, expc);
            #1;
            chk(done_o, "R6", "done after readback", done_o, 1);
        end

        // R6 rearm clears done
        arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
        #1;
        chk(!done_o, "R6", "done after rearm", done_o, 0);

        // R8 abort mid-capture, no trigger pattern present
        send_cfg(16'h0300, 8'hFF, 8'h00, 8'h01);
        probe_i    = 8'h00;
        post_cnt_i = 16'd2;
        arm_i      = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
        repeat (5) @(negedge clk);
        abort_i = 1'b1;
        #1;
        chk(!wr_en_o, "R8", "wr_en in abort cycle", wr_en_o, 0);
        @(negedge clk);
        abort_i = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(!done_o && !wr_en_o, "R8", "idle after abort", {done_o, wr_en_o}, 0);
        @(negedge clk);
        read_cnt(rv);
        chk(rv == 16'h0305, "R8", "counter held at abort", rv, 16'h0305);

        // R1 new setup overwrites counter
        send_cfg(16'h0ABC, 8'h00, 8'h00, 8'h01);
        read_cnt(rv);
        chk(rv == 16'h0ABC, "R1", "counter after commit", rv, 16'h0ABC);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule